// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of a parameterised width and returns the exact product at twice that width, with no truncation. It recodes the multiplier operand into radix-4 signed digits. Each digit comes from a window of three adjacent bits, and consecutive windows share one bit. Each digit picks zero, one or two times the multiplicand, positive or negative, as its addend. This gives about half as many partial products as a plain shift-and-add array.

The partial products are summed in a combinational adder chain. The product is captured in an output register, together with a valid flag. A new operand pair can be presented on every cycle, and its result appears one clock edge later. The product register keeps its value on cycles that carry no valid operands.

Top module: `booth_mul`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `product` after that edge equals the signed product of `mcand` and `mplier`, taken as a two's-complement value of 2*WIDTH bits.
- R2: The multiplier is recoded in overlapping three-bit windows, with a 0 placed below its bit 0. Window k covers extended bits 2k+2..2k and selects an addend of weight 4^k as follows: 000 and 111 select 0, 001 and 010 select +a, 011 selects +2a, 100 selects -2a, and 101 and 110 select -a. Multipliers such as 1, 2, 3, -1, -2 and alternating bit patterns therefore give exact products.
- R3: Operands at the signed extremes give the exact result with no overflow. For WIDTH=16, -32768 times -32768 gives 32'h4000_0000.
- R4: `out_valid` after a rising edge equals `in_valid` before that edge, so the latency is exactly one cycle.
- R5: While `rst_n` is low, `out_valid` and `product` are 0.
- R6: A rising edge with `in_valid` low leaves `product` unchanged, whatever `mcand` and `mplier` carry.
- R7: An odd WIDTH is supported by sign-extending the multiplier by one bit. For WIDTH=7, -64 times -64 gives 14'h1000 and 63 times -64 gives -4032.
- R8: A zero on either operand gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier (Booth-recoded operand) |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | 2*WIDTH | Signed full-width product |

## Verification
The bench chooses multipliers whose windows hit every recoding class: 1, 2, 3, -1, -2, 0x5555 and 0xAAAA. A swapped or mis-signed entry in the digit table shows up as a product that is off by a multiple of the multiplicand. The most negative operand squared checks that addends are sign-extended to full width and that the top bits are not truncated. A design that dropped the extension would return a negative or wrapped value here. A 7-bit instance checks the extra sign bit needed for odd widths; without it, negative multipliers lose their top digit. Hold cycles with changing operands catch a register that loads without a valid flag.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // Radix-4 signed digit selected by one three-bit window.
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } booth_digit_e;

    // Number of radix-4 digits for a given operand width.
    function automatic int unsigned digit_count(input int unsigned w);
        return (w + 1) / 2;
    endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
    import booth_mul_pkg::*;
(
    input  logic [2:0]   window,
    output booth_digit_e digit
);

    always_comb begin
        unique case (window)
            3'b001, 3'b010: digit = DIG_POS1;
            3'b011:         digit = DIG_POS2;
            3'b100:         digit = DIG_NEG2;
            3'b101, 3'b110: digit = DIG_NEG1;
            default:        digit = DIG_ZERO;   // 000 and 111
        endcase
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_mul_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned SHIFT = 0,
    localparam int unsigned PW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_digit_e     digit,
    output logic [PW-1:0]    pp
);

    logic [PW-1:0] base;
    logic [PW-1:0] mag;

    // Sign-extend the multiplicand to the full product width.
    assign base = {{(PW-WIDTH){mcand[WIDTH-1]}}, mcand};

    always_comb begin
        unique case (digit)
            DIG_POS1: mag = base;
            DIG_POS2: mag = base << 1;
            DIG_NEG1: mag = ~base + PW'(1);
            DIG_NEG2: mag = ~(base << 1) + PW'(1);
            default:  mag = '0;
        endcase
    end

    assign pp = mag << SHIFT;

endmodule

// File: rtl/booth_pp_sum.sv
module booth_pp_sum #(
    parameter int unsigned PW   = 32,
    parameter int unsigned NPP  = 8
) (
    input  logic [NPP-1:0][PW-1:0] pps,
    output logic [PW-1:0]          sum
);

    logic [NPP:0][PW-1:0] acc;

    assign acc[0] = '0;

    for (genvar k = 0; k < NPP; k++) begin : g_add
        assign acc[k+1] = acc[k] + pps[k];
    end

    assign sum = acc[NPP];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_mul_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned PW   = 2 * WIDTH,
    localparam int unsigned NDIG = digit_count(WIDTH),
    localparam int unsigned EW   = 2 * NDIG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             out_valid,
    output logic [PW-1:0]    product
);

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] prod;
    } out_state_t;

    out_state_t state_d, state_q;

    // Multiplier extended to whole digits, with a 0 placed below bit 0.
    logic [EW:0] mpl_ext;

    if (EW != WIDTH) begin : g_odd
        assign mpl_ext = {mplier[WIDTH-1], mplier, 1'b0};
    end else begin : g_even
        assign mpl_ext = {mplier, 1'b0};
    end

    logic [NDIG-1:0][PW-1:0] pps;
    logic [PW-1:0]           sum;

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        booth_digit_e digit;

        booth_digit_enc i_enc (
            .window (mpl_ext[2*k+2 -: 3]),
            .digit  (digit)
        );

        booth_pp_gen #(
            .WIDTH (WIDTH),
            .SHIFT (2*k)
        ) i_pp (
            .mcand (mcand),
            .digit (digit),
            .pp    (pps[k])
        );
    end

    booth_pp_sum #(
        .PW  (PW),
        .NPP (NDIG)
    ) i_sum (
        .pps (pps),
        .sum (sum)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.prod = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign product   = state_q.prod;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned PW   = 2 * WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] mcand,
    input logic [WIDTH-1:0] mplier,
    input logic             out_valid,
    input logic [PW-1:0]    product
);

    logic [PW-1:0] ref_prod;

    // Reference by plain multiplication of sign-extended operands.
    assign ref_prod = {{(PW-WIDTH){mcand[WIDTH-1]}}, mcand}
                    * {{(PW-WIDTH){mplier[WIDTH-1]}}, mplier};

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product == $past(ref_prod));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid) || $past(!rst_n));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mcand == '0 || mplier == '0)) |=> product == '0);

    always_comb begin
        if (!rst_n) begin
            p_reset_r5: assert (!out_valid && product == '0);
        end
    end

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplier    (mplier),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_booth_mul.sv
module test_booth_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic        v16 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        ov16;
    logic [31:0] p16;

    logic        v7 = 1'b0;
    logic [6:0]  a7 = '0, b7 = '0;
    logic        ov7;
    logic [13:0] p7;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    booth_mul #(.WIDTH(16)) i_booth_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .mcand(a16), .mplier(b16),
        .out_valid(ov16), .product(p16)
    );

    booth_mul #(.WIDTH(7)) i_booth_mul_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(v7), .mcand(a7), .mplier(b7),
        .out_valid(ov7), .product(p7)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref16(input logic [15:0] a, input logic [15:0] b);
        return {{16{a[15]}}, a} * {{16{b[15]}}, b};
    endfunction

    function automatic logic [13:0] ref7(input logic [6:0] a, input logic [6:0] b);
        return {{7{a[6]}}, a} * {{7{b[6]}}, b};
    endfunction

    task automatic mul16(input string req, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        a16 = a; b16 = b; v16 = 1'b1;
        @(negedge clk);
        v16 = 1'b0;
        chk(req, 64'(p16), 64'(ref16(a, b)));
        chk("R4 valid after one edge", 64'(ov16), 64'd1);
    endtask

    task automatic mul7(input string req, input logic [6:0] a, input logic [6:0] b);
        @(negedge clk);
        a7 = a; b7 = b; v7 = 1'b1;
        @(negedge clk);
        v7 = 1'b0;
        chk(req, 64'(p7), 64'(ref7(a, b)));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R5 reset out_valid", 64'(ov16), 64'd0);
        chk("R5 reset product", 64'(p16), 64'd0);
        chk("R5 reset product odd", 64'(p7), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_encodings;   // R2
        mul16("R2 b=1", 16'd1234, 16'd1);
        mul16("R2 b=2", 16'd1234, 16'd2);
        mul16("R2 b=3", 16'hFB2E, 16'd3);
        mul16("R2 b=-1", 16'd777, 16'hFFFF);
        mul16("R2 b=-2", 16'd777, 16'hFFFE);
        mul16("R2 b=5555", 16'h7123, 16'h5555);
        mul16("R2 b=AAAA", 16'h9123, 16'hAAAA);
        mul16("R2 b=6", 16'hFFFF, 16'd6);
    endtask

    task automatic t_extremes;    // R3
        mul16("R3 min*min", 16'h8000, 16'h8000);
        chk("R3 min*min literal", 64'(p16), 64'h4000_0000);
        mul16("R3 min*max", 16'h8000, 16'h7FFF);
        mul16("R3 max*max", 16'h7FFF, 16'h7FFF);
        mul16("R3 max*min", 16'h7FFF, 16'h8000);
    endtask

    task automatic t_zero;        // R8
        mul16("R8 a=0", 16'h0000, 16'hBEEF);
        chk("R8 a=0 literal", 64'(p16), 64'd0);
        mul16("R8 b=0", 16'h8001, 16'h0000);
        chk("R8 b=0 literal", 64'(p16), 64'd0);
    endtask

    task automatic t_hold;        // R6, R4
        logic [31:0] kept;
        mul16("R1 before hold", 16'd300, 16'hFF00);
        kept = p16;
        a16 = 16'h1111; b16 = 16'h2222;
        @(negedge clk);
        chk("R4 valid drops", 64'(ov16), 64'd0);
        chk("R6 hold 1", 64'(p16), 64'(kept));
        a16 = 16'h8000; b16 = 16'h8000;
        @(negedge clk);
        chk("R6 hold 2", 64'(p16), 64'(kept));
    endtask

    task automatic t_odd;         // R7
        mul7("R7 min*min", 7'h40, 7'h40);
        chk("R7 min*min literal", 64'(p7), 64'h1000);
        mul7("R7 63*-64", 7'h3F, 7'h40);
        chk("R7 63*-64 literal", 64'(p7), 64'(14'h3FFF - 14'd4031));
        mul7("R7 -1*-1", 7'h7F, 7'h7F);
        for (int i = 0; i < 40; i++) begin
            mul7("R7 sweep", 7'($urandom), 7'($urandom));
        end
    endtask

    task automatic t_random;      // R1
        for (int i = 0; i < 200; i++) begin
            mul16("R1 random", 16'($urandom), 16'($urandom));
        end
    endtask

    task automatic t_back_to_back;   // R1, R4 with consecutive valids
        @(negedge clk);
        a16 = 16'd100; b16 = 16'hFFF6; v16 = 1'b1;
        @(negedge clk);
        chk("R1 stream 1", 64'(p16), 64'(ref16(16'd100, 16'hFFF6)));
        a16 = 16'hC000; b16 = 16'd3;
        @(negedge clk);
        chk("R1 stream 2", 64'(p16), 64'(ref16(16'hC000, 16'd3)));
        chk("R4 stream valid", 64'(ov16), 64'd1);
        v16 = 1'b0;
        @(negedge clk);
        chk("R4 stream end", 64'(ov16), 64'd0);
    endtask

    initial begin
        t_reset();
        t_encodings();
        t_extremes();
        t_zero();
        t_hold();
        t_odd();
        t_random();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule